// File: doc/BRIEF.md
# Timed bus-line override sequencer

This block follows a slow address line and, at one exact clock cycle, takes over a shared data line for a short window. It runs on one system clock. When started, it first aligns to the level of the primary address line. After that it waits through a long settling window, then counts a set number of edges on the primary line. On the last of those edges it waits a fine offset, enables its data-line driver for a few cycles, and then releases the line. A build option adds a second stage that does the same on a secondary address line.

Every delay and count is a parameter measured in clock cycles. Both address inputs pass through a two-flop synchronizer. The fixed synchronizer latency is already part of the offset parameters, so each offset is measured from the clock edge that first samples the triggering line edge. The block drives only a value and an enable. The pad that combines them sits outside it.

Top module: `bus_override_seq`

## Requirements
- R1: On `start_i` with `bypass_i` low, if the synchronized primary line is high the block waits for it to go low and then for a rising edge; if it is low it waits only for the next rising edge. `busy_o` first reads 1 in the cycle after the (BOOT_CYC+3)-th clock edge, counting as edge 1 the edge that first samples the aligning rise.
- R2: Primary-line edges during the boot window are not counted.
- R3: After the boot window, the override fires on the PULSE1-th counted primary edge and not on an earlier one.
- R4: With FALL_EDGE=1 the counted primary edges are falling edges, and rising edges are not counted. With FALL_EDGE=0 they are rising edges.
- R5: `dat_oe_o` first reads 1 in the cycle after the OFFSET1-th clock edge, counting as edge 1 the edge that first samples the triggering line edge. It stays 1 for exactly OVR1 cycles and then returns to 0.
- R6: With DRIVE_HIGH=1, `dat_o` is 1 throughout the first override window. In every other case `dat_o` is 0. `dat_o` is never 1 while `dat_oe_o` is 0.
- R7: `stage_o` counts completed overrides: 0 before any, 1 after the first, 2 after the second. After the first override, edges on the primary line are not counted. `done_o` goes to 1 when the whole sequence has finished.
- R8: With TWO_STAGE=1, after the first override the block waits for the secondary line to be low. It then waits FOLLOW_CYC cycles, during which secondary edges are ignored. Next it counts PULSE2 rising edges of the secondary line and applies an override timed by OFFSET2 and OVR2 in the same way as R5, with `dat_o` at 0.
- R9: `busy_o` is 1 from the moment edge counting is armed until the final override releases the line, including the whole gap between the two stages. It is 0 otherwise.
- R10: If `bypass_i` is high when `start_i` is taken, the block goes straight to `done_o`=1 with `stage_o`=0. It never drives the line and never raises `busy_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts the sequence from idle |
| bypass_i | input | 1 | When high at start, skips the whole sequence |
| addr_pri_i | input | 1 | Primary address line, asynchronous |
| addr_sec_i | input | 1 | Secondary address line, asynchronous |
| dat_o | output | 1 | Value to drive onto the data line |
| dat_oe_o | output | 1 | Data-line driver enable |
| busy_o | output | 1 | Edge counting armed or override pending |
| done_o | output | 1 | Sequence finished |
| stage_o | output | 2 | Number of overrides completed |

## Verification
Each result is due a fixed number of clock edges after the stimulus that causes it. For `busy_o`, that is BOOT_CYC+3 edges after the aligning rise is sampled. For `dat_oe_o`, it is OFFSET1 or OFFSET2 edges after the final counted edge is sampled, and the window then lasts OVR1 or OVR2 cycles. The bench changes the address lines just after a falling clock edge. It then counts rising edges one at a time and reads the outputs at the following falling edge, so the cycle index at which `dat_oe_o` first reads 1 is compared directly with the offset parameter. Edges placed inside the boot and follow-up windows, and primary edges between stages, would shift that index if they were counted wrongly.

// File: rtl/ovr_seq_pkg.sv
package ovr_seq_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_WLOW,
      ST_WRISE,
      ST_BOOT,
      ST_COUNT,
      ST_OFST,
      ST_DRIVE,
      ST_WSEC,
      ST_FOLLOW,
      ST_FIN
   } seq_state_t;

   localparam int SYNC_DEPTH = 2;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ovr_line_sync.sv
module ovr_line_sync #(
   parameter int DEPTH = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic level_o,
   output logic last_o
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("ovr_line_sync: DEPTH must be at least 2");
   end

   logic [DEPTH-1:0] chain_q;
   logic             last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[DEPTH-2:0], line_i};
         last_q  <= chain_q[DEPTH-1];
      end
   end

   assign level_o = chain_q[DEPTH-1];
   assign last_o  = last_q;

endmodule

// File: rtl/ovr_down_counter.sv
module ovr_down_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   input  logic         dec_i,
   output logic [W-1:0] count_o
);

   if (W < 1) begin : g_bad_width
      $error("ovr_down_counter: W must be positive");
   end

   logic [W-1:0] count_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (load_i) begin
         count_q <= load_val_i;
      end else if (dec_i) begin
         count_q <= count_q - W'(1);
      end
   end

   assign count_o = count_q;

   // R3: the sequencer never steps a counter below zero
   a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_i && !load_i) |-> (count_o != '0));

endmodule

// File: rtl/bus_override_seq.sv
module bus_override_seq
   import ovr_seq_pkg::*;
#(
   parameter int BOOT_CYC   = 1344000,
   parameter int FOLLOW_CYC = 160000,
   parameter int PULSE1     = 48,
   parameter int PULSE2     = 16,
   parameter int OFFSET1    = 47,
   parameter int OFFSET2    = 47,
   parameter int OVR1       = 3,
   parameter int OVR2       = 3,
   parameter int FALL_EDGE  = 0,
   parameter int TWO_STAGE  = 0,
   parameter int DRIVE_HIGH = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       bypass_i,
   input  logic       addr_pri_i,
   input  logic       addr_sec_i,
   output logic       dat_o,
   output logic       dat_oe_o,
   output logic       busy_o,
   output logic       done_o,
   output logic [1:0] stage_o
);

   localparam int LAT      = SYNC_DEPTH + 1;
   localparam int OFS1_INT = OFFSET1 - LAT;
   localparam int OFS2_INT = OFFSET2 - LAT;
   localparam int DLY_MAX  = max2(max2(BOOT_CYC, FOLLOW_CYC),
                                  max2(max2(OFS1_INT, OFS2_INT), max2(OVR1, OVR2)));
   localparam int TW       = $clog2(DLY_MAX + 1);
   localparam int CW       = $clog2(max2(PULSE1, PULSE2) + 1);
   localparam int OVR_MAX  = max2(OVR1, OVR2);

   localparam logic [TW-1:0] BOOT_LD   = TW'(BOOT_CYC - 1);
   localparam logic [TW-1:0] FOLLOW_LD = TW'(FOLLOW_CYC - 1);
   localparam logic [TW-1:0] OFS1_LD   = TW'(OFS1_INT - 1);
   localparam logic [TW-1:0] OFS2_LD   = TW'(OFS2_INT - 1);
   localparam logic [TW-1:0] OVR1_LD   = TW'(OVR1 - 1);
   localparam logic [TW-1:0] OVR2_LD   = TW'(OVR2 - 1);
   localparam logic [CW-1:0] P1_LD     = CW'(PULSE1);
   localparam logic [CW-1:0] P2_LD     = CW'(PULSE2);

   // elaboration-time parameter checks
   if (OFS1_INT < 1 || OFS2_INT < 1) begin : g_bad_offset
      $error("bus_override_seq: offsets must exceed synchronizer latency plus one");
   end
   if (BOOT_CYC < 1 || FOLLOW_CYC < 1 || OVR1 < 1 || OVR2 < 1) begin : g_bad_delay
      $error("bus_override_seq: delays and windows must be at least one cycle");
   end
   if (PULSE1 < 1 || PULSE2 < 1) begin : g_bad_pulse
      $error("bus_override_seq: pulse counts must be at least one");
   end
   if (TWO_STAGE != 0 && FALL_EDGE != 0) begin : g_bad_variant
      $error("bus_override_seq: the two-stage variant counts rising edges only");
   end

   // synchronizers and edge detection
   logic pri_lvl, pri_last, sec_lvl, sec_last;
   logic pri_rise, sec_rise, pri_cnt_evt;

   ovr_line_sync #(.DEPTH(SYNC_DEPTH)) u_sync_pri (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_i  (addr_pri_i),
      .level_o (pri_lvl),
      .last_o  (pri_last)
   );

   ovr_line_sync #(.DEPTH(SYNC_DEPTH)) u_sync_sec (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_i  (addr_sec_i),
      .level_o (sec_lvl),
      .last_o  (sec_last)
   );

   assign pri_rise = pri_lvl & ~pri_last;
   assign sec_rise = sec_lvl & ~sec_last;

   if (FALL_EDGE != 0) begin : g_cnt_fall
      assign pri_cnt_evt = ~pri_lvl & pri_last;
   end else begin : g_cnt_rise
      assign pri_cnt_evt = pri_rise;
   end

   // sequencer state
   seq_state_t st_q, st_d;
   logic       phase_q;
   logic [1:0] stage_q;

   logic          tmr_ld, tmr_dec, tmr_zero;
   logic [TW-1:0] tmr_val, tmr_q;
   logic          cnt_ld, cnt_dec, cnt_evt;
   logic [CW-1:0] cnt_val, cnt_q;
   logic          stage_inc, phase_set, timed;

   assign cnt_evt  = phase_q ? sec_rise : pri_cnt_evt;
   assign tmr_zero = (tmr_q == '0);
   assign timed    = (st_q == ST_BOOT) || (st_q == ST_OFST) ||
                     (st_q == ST_DRIVE) || (st_q == ST_FOLLOW);

   always_comb begin
      st_d      = st_q;
      tmr_ld    = 1'b0;
      tmr_val   = '0;
      cnt_ld    = 1'b0;
      cnt_val   = '0;
      stage_inc = 1'b0;
      phase_set = 1'b0;
      case (st_q)
         ST_IDLE: begin
            if (start_i) begin
               if (bypass_i)     st_d = ST_FIN;
               else if (pri_lvl) st_d = ST_WLOW;
               else              st_d = ST_WRISE;
            end
         end
         ST_WLOW: begin
            if (!pri_lvl) st_d = ST_WRISE;
         end
         ST_WRISE: begin
            if (pri_rise) begin
               st_d    = ST_BOOT;
               tmr_ld  = 1'b1;
               tmr_val = BOOT_LD;
            end
         end
         ST_BOOT: begin
            if (tmr_zero) begin
               st_d    = ST_COUNT;
               cnt_ld  = 1'b1;
               cnt_val = P1_LD;
            end
         end
         ST_COUNT: begin
            if (cnt_evt && cnt_q == CW'(1)) begin
               st_d    = ST_OFST;
               tmr_ld  = 1'b1;
               tmr_val = phase_q ? OFS2_LD : OFS1_LD;
            end
         end
         ST_OFST: begin
            if (tmr_zero) begin
               st_d    = ST_DRIVE;
               tmr_ld  = 1'b1;
               tmr_val = phase_q ? OVR2_LD : OVR1_LD;
            end
         end
         ST_DRIVE: begin
            if (tmr_zero) begin
               stage_inc = 1'b1;
               if (TWO_STAGE != 0 && !phase_q) begin
                  st_d      = ST_WSEC;
                  phase_set = 1'b1;
               end else begin
                  st_d = ST_FIN;
               end
            end
         end
         ST_WSEC: begin
            if (!sec_lvl) begin
               st_d    = ST_FOLLOW;
               tmr_ld  = 1'b1;
               tmr_val = FOLLOW_LD;
            end
         end
         ST_FOLLOW: begin
            if (tmr_zero) begin
               st_d    = ST_COUNT;
               cnt_ld  = 1'b1;
               cnt_val = P2_LD;
            end
         end
         ST_FIN: begin
            st_d = ST_FIN;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   assign tmr_dec = timed && !tmr_zero && !tmr_ld;
   assign cnt_dec = (st_q == ST_COUNT) && cnt_evt && !cnt_ld;

   ovr_down_counter #(.W(TW)) u_delay (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (tmr_ld),
      .load_val_i (tmr_val),
      .dec_i      (tmr_dec),
      .count_o    (tmr_q)
   );

   ovr_down_counter #(.W(CW)) u_pulses (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (cnt_ld),
      .load_val_i (cnt_val),
      .dec_i      (cnt_dec),
      .count_o    (cnt_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         phase_q <= 1'b0;
         stage_q <= 2'd0;
      end else begin
         st_q <= st_d;
         if (phase_set) phase_q <= 1'b1;
         if (stage_inc) stage_q <= stage_q + 2'd1;
      end
   end

   // outputs
   assign dat_oe_o = (st_q == ST_DRIVE);
   assign busy_o   = (st_q == ST_COUNT) || (st_q == ST_OFST) || (st_q == ST_DRIVE) ||
                     (st_q == ST_WSEC)  || (st_q == ST_FOLLOW);
   assign done_o   = (st_q == ST_FIN);
   assign stage_o  = stage_q;

   if (DRIVE_HIGH != 0) begin : g_drive_high
      assign dat_o = (st_q == ST_DRIVE) && !phase_q;
   end else begin : g_drive_low
      assign dat_o = 1'b0;
   end

   // assertions
   logic [TW-1:0] oe_run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        oe_run_q <= '0;
      else if (dat_oe_o) oe_run_q <= oe_run_q + TW'(1);
      else               oe_run_q <= '0;
   end

   // R5: the driver is never enabled longer than the widest window
   a_r5_window_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      dat_oe_o |-> (oe_run_q < TW'(OVR_MAX)));

   // R6: a driven value only appears with the enable
   a_r6_dat_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
      dat_o |-> dat_oe_o);

   // R7: each release of the line advances the stage count by one
   a_r7_stage_on_release: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dat_oe_o) |-> (stage_o == $past(stage_o) + 2'd1));

   // R7: the stage count only ever steps upward by one
   a_r7_stage_step: assert property (@(posedge clk) disable iff (!rst_n)
      (stage_o != $past(stage_o)) |-> (stage_o == $past(stage_o) + 2'd1));

   // R8: no more overrides than the variant allows
   a_r8_stage_limit: assert property (@(posedge clk) disable iff (!rst_n)
      stage_o <= ((TWO_STAGE != 0) ? 2'd2 : 2'd1));

endmodule

// File: tb/tb_bus_override_seq.sv
`timescale 1ns/1ps
module tb_bus_override_seq;

   localparam int A_BOOT = 30, A_FOLLOW = 25, A_P1 = 4, A_P2 = 3;
   localparam int A_OFS1 = 7, A_OFS2 = 5, A_OVR1 = 3, A_OVR2 = 2;
   localparam int F_BOOT = 30, F_P1 = 5, F_OFS1 = 9, F_OVR1 = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic a_start = 0, a_byp = 0, a_pri = 0, a_sec = 0;
   logic a_dat, a_oe, a_busy, a_done;
   logic [1:0] a_stage;
   logic f_start = 0, f_byp = 0, f_pri = 0, f_sec = 0;
   logic f_dat, f_oe, f_busy, f_done;
   logic [1:0] f_stage;

   bus_override_seq #(
      .BOOT_CYC(A_BOOT), .FOLLOW_CYC(A_FOLLOW), .PULSE1(A_P1), .PULSE2(A_P2),
      .OFFSET1(A_OFS1), .OFFSET2(A_OFS2), .OVR1(A_OVR1), .OVR2(A_OVR2),
      .FALL_EDGE(0), .TWO_STAGE(1), .DRIVE_HIGH(1)
   ) dut (
      .clk(clk), .rst_n(rst_n), .start_i(a_start), .bypass_i(a_byp),
      .addr_pri_i(a_pri), .addr_sec_i(a_sec), .dat_o(a_dat), .dat_oe_o(a_oe),
      .busy_o(a_busy), .done_o(a_done), .stage_o(a_stage)
   );

   bus_override_seq #(
      .BOOT_CYC(F_BOOT), .FOLLOW_CYC(10), .PULSE1(F_P1), .PULSE2(2),
      .OFFSET1(F_OFS1), .OFFSET2(6), .OVR1(F_OVR1), .OVR2(2),
      .FALL_EDGE(1), .TWO_STAGE(0), .DRIVE_HIGH(0)
   ) dut_f (
      .clk(clk), .rst_n(rst_n), .start_i(f_start), .bypass_i(f_byp),
      .addr_pri_i(f_pri), .addr_sec_i(f_sec), .dat_o(f_dat), .dat_oe_o(f_oe),
      .busy_o(f_busy), .done_o(f_done), .stage_o(f_stage)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic set_line(input int sel, input logic v);
      case (sel)
         0: a_pri = v;
         1: a_sec = v;
         default: f_pri = v;
      endcase
   endtask

   function automatic logic get_oe(input int sel);
      return (sel == 2) ? f_oe : a_oe;
   endfunction

   function automatic logic get_dat(input int sel);
      return (sel == 2) ? f_dat : a_dat;
   endfunction

   function automatic logic get_busy(input int sel);
      return (sel == 2) ? f_busy : a_busy;
   endfunction

   task automatic do_reset();
      rst_n = 0;
      a_start = 0; a_byp = 0; a_pri = 0; a_sec = 0;
      f_start = 0; f_byp = 0; f_pri = 0; f_sec = 0;
      repeat (4) tick();
      rst_n = 1;
      repeat (3) tick();
   endtask

   task automatic pulse_start(input int sel);
      if (sel == 2) f_start = 1; else a_start = 1;
      tick();
      if (sel == 2) f_start = 0; else a_start = 0;
   endtask

   // R1 R2 R9: alignment then boot window with ignored edges inside it
   task automatic align_boot(input int sel, input bit hi_start, input int boot);
      int busy_hi_at;
      if (hi_start) begin
         set_line(sel, 1);
         repeat (5) tick();
         pulse_start(sel);
         repeat (2) tick();
         set_line(sel, 0);
         repeat (3) tick();
      end else begin
         set_line(sel, 0);
         repeat (3) tick();
         pulse_start(sel);
         repeat (3) tick();
      end
      chk(get_busy(sel) == 1'b0, "R9 busy low before arming", get_busy(sel), 0);
      set_line(sel, 1);
      busy_hi_at = -1;
      for (int n = 1; n <= boot + 5; n++) begin
         tick();
         if (n == 2)  set_line(sel, 0);
         if (n == 6)  set_line(sel, 1);
         if (n == 8)  set_line(sel, 0);
         if (n == 10) set_line(sel, 1);
         if (n == 12) set_line(sel, 0);
         if (busy_hi_at < 0 && get_busy(sel)) busy_hi_at = n;
      end
      chk(busy_hi_at == boot + 3, "R1 busy rise after boot window", busy_hi_at, boot + 3);
   endtask

   task automatic count_pulses(input int sel, input int k, input string req);
      bit quiet = 1;
      for (int i = 0; i < k; i++) begin
         set_line(sel, 1);
         tick(); if (get_oe(sel)) quiet = 0;
         tick(); if (get_oe(sel)) quiet = 0;
         set_line(sel, 0);
         tick(); if (get_oe(sel)) quiet = 0;
         tick(); if (get_oe(sel)) quiet = 0;
      end
      chk(quiet, req, !quiet, 0);
   endtask

   task automatic measure(input int sel, input logic evt, input bit restore,
                          input int exp_ofs, input int exp_ovr, input logic exp_dat,
                          input string req);
      int n = 0;
      int len = 0;
      bit got = 0;
      bit dat_ok = 1;
      set_line(sel, evt);
      while (!got && n < 200) begin
         tick();
         n++;
         if (n == 2 && restore) set_line(sel, ~evt);
         if (get_oe(sel)) got = 1;
         else if (get_dat(sel)) dat_ok = 0;
      end
      chk(n == exp_ofs, {req, " override start cycle"}, n, exp_ofs);
      while (get_oe(sel) && len < 200) begin
         len++;
         if (get_dat(sel) != exp_dat) dat_ok = 0;
         tick();
      end
      chk(len == exp_ovr, {req, " override length"}, len, exp_ovr);
      chk(dat_ok && get_dat(sel) == 1'b0, "R6 drive value", get_dat(sel), 0);
   endtask

   task automatic t_reset();
      do_reset();
      chk(a_oe == 0 && f_oe == 0, "R5 reset enable low", a_oe, 0);
      chk(a_busy == 0 && a_done == 0, "R9 reset busy/done low", a_busy, 0);
      chk(a_stage == 2'd0 && a_dat == 0, "R7 reset stage zero", a_stage, 0);
   endtask

   task automatic t_two_stage();
      do_reset();
      a_sec = 1;
      align_boot(0, 1'b1, A_BOOT);
      count_pulses(0, A_P1 - 1, "R3 no early override");
      measure(0, 1'b1, 1'b1, A_OFS1, A_OVR1, 1'b1, "R5");
      chk(a_stage == 2'd1, "R7 stage after first override", a_stage, 1);
      chk(a_busy == 1 && a_done == 0, "R9 busy between stages", a_busy, 1);
      count_pulses(0, 3, "R7 primary ignored after stage 1");
      repeat (5) tick();
      chk(a_busy == 1 && a_stage == 2'd1, "R8 waits for secondary low", a_busy, 1);
      a_sec = 0;
      for (int n = 1; n <= A_FOLLOW + 8; n++) begin
         tick();
         if (n == 5)  a_sec = 1;
         if (n == 7)  a_sec = 0;
         if (n == 9)  a_pri = 1;
         if (n == 11) a_pri = 0;
      end
      chk(a_oe == 0, "R8 follow window quiet", a_oe, 0);
      count_pulses(1, A_P2 - 1, "R8 no early second override");
      measure(1, 1'b1, 1'b1, A_OFS2, A_OVR2, 1'b0, "R8");
      tick();
      chk(a_stage == 2'd2, "R8 stage after second override", a_stage, 2);
      chk(a_done == 1 && a_busy == 0, "R9 busy low after final release", a_busy, 0);
   endtask

   task automatic t_bypass();
      bit quiet = 1;
      do_reset();
      a_byp = 1;
      pulse_start(0);
      a_byp = 0;
      repeat (2) tick();
      chk(a_done == 1 && a_stage == 2'd0, "R10 bypass done at stage 0", a_stage, 0);
      for (int i = 0; i < 60; i++) begin
         a_pri = ~a_pri;
         tick();
         if (a_oe || a_busy) quiet = 0;
      end
      chk(quiet, "R10 bypass never drives", !quiet, 0);
      chk(a_done == 1 && a_stage == 2'd0, "R10 bypass final state", a_stage, 0);
   endtask

   task automatic t_falling();
      do_reset();
      align_boot(2, 1'b0, F_BOOT);
      count_pulses(2, F_P1 - 1, "R4 falling edges counted");
      f_pri = 1;
      tick();
      tick();
      chk(f_oe == 0, "R4 rising edge not counted", f_oe, 0);
      measure(2, 1'b0, 1'b0, F_OFS1, F_OVR1, 1'b0, "R4");
      tick();
      chk(f_stage == 2'd1 && f_done == 1, "R7 single stage done", f_stage, 1);
      chk(f_busy == 0, "R9 busy low when finished", f_busy, 0);
   endtask

   initial begin
      t_reset();
      t_two_stage();
      t_bypass();
      t_falling();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      finished = 1;
      $finish;
   end

   initial begin
      repeat (60000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule